// File: doc/BRIEF.md
# Shared Memory Bus Arbiter

This block decides, cycle by cycle, who drives a single memory bus that a processor shares with a set of DMA clients. The processor always comes first: whenever it asks for the bus and no client word is in flight, its address, write strobe and write data go straight to the memory in that same cycle. Clients fill the gaps. A client can start a word transfer only at a clock edge where the processor is not asking. Once started, the transfer runs for a fixed number of cycles and is never cut short. A processor request that collides with a running transfer is held off with a wait signal until that word completes. The processor is then served in the next cycle.

The clients are, in index order, command ingest (0), telemetry readout (1), science-data ingest (2) and bulk-storage transfer (the highest index). Among clients, a lower index wins. The bulk-storage client can be throttled. When throttling is on, each bulk grant locks the bulk client out of a programmable number of following arbitration slots, which bounds its share of bus time. The other clients are not affected by the lockout. Read data from the memory is returned to the processor and to the clients on shared read ports. The owner decides who uses it.

Top module: `mem_bus_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no client grant or done bit is set and the processor wait signal is low.
- R2: When the processor requests and no client grant is active, the wait signal is low in that cycle. In the same cycle the memory enable is high and the memory address, write strobe and write data equal the processor's.
- R3: A client grant starts only at a clock edge where the processor request is low and that client's request is high. While the processor keeps requesting, no client is granted.
- R4: A grant is one-hot and stays on one client for exactly XFER_CYC cycles. During those cycles the memory bus carries that client's address, write strobe and write data. That client's done bit is high only in the last of those cycles.
- R5: The processor wait signal is high in every cycle where the processor requests while a client grant is active. In the cycle after the done cycle, the grant is clear and the processor owns the bus.
- R6: At a start edge with several eligible requests, the client with the lowest index is granted.
- R7: With throttling enabled and a gap G, after a bulk grant the bulk client is passed over at the next G arbitration slots. An arbitration slot is a clock edge where no transfer continues and the processor does not request. With XFER_CYC=2, G=3 and a steady bulk request, the pattern is 2 granted cycles followed by 3 idle cycles.
- R8: With throttling disabled, a bulk client that keeps requesting is granted again in the cycle right after its done cycle.
- R9: The lockout blocks only the bulk client. A lower-index client that requests during the lockout is granted at the first arbitration slot.
- R10: The processor and client read-data outputs equal the memory read data in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor bus request for the current cycle |
| cpu_we | input | 1 | Processor write strobe |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Read data returned to the processor |
| cpu_wait | output | 1 | Wait state: processor request not served this cycle |
| cli_req | input | NCLI | Client requests, bit k for client k |
| cli_we | input | NCLI | Client write strobes |
| cli_addr | input | NCLI*AW | Client addresses, client k in bits k*AW upward |
| cli_wdata | input | NCLI*DW | Client write data, client k in bits k*DW upward |
| cli_gnt | output | NCLI | Registered one-hot client grant |
| cli_done | output | NCLI | Last cycle of the granted client's word |
| cli_rdata | output | DW | Read data returned to the clients |
| thr_en | input | 1 | Enables the bulk-client throttle |
| thr_gap | input | GAP_W | Arbitration slots the bulk client sits out after each grant |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |

## Verification
The bench builds the arbiter with four clients, 8-bit address and data, XFER_CYC=2 and a 4-bit gap. The two-cycle word gives every transfer a middle cycle, a done cycle and a collision cycle in which the processor is stalled. The bench can therefore see the wait signal span more than one cycle and drop exactly after the done pulse. A gap of 3 makes the throttled bulk pattern short enough to cover two full periods. It also leaves room to interleave a telemetry grant inside the lockout and to watch the bulk client come back once the lockout counts out.

// File: rtl/mem_bus_arbiter.sv
module mem_bus_arbiter #(
  parameter int NCLI     = 4,
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int XFER_CYC = 2,
  parameter int GAP_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_wait,
  input  logic [NCLI-1:0]   cli_req,
  input  logic [NCLI-1:0]   cli_we,
  input  logic [NCLI*AW-1:0] cli_addr,
  input  logic [NCLI*DW-1:0] cli_wdata,
  output logic [NCLI-1:0]   cli_gnt,
  output logic [NCLI-1:0]   cli_done,
  output logic [DW-1:0]     cli_rdata,
  input  logic              thr_en,
  input  logic [GAP_W-1:0]  thr_gap,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);
  localparam int CW   = $clog2(XFER_CYC + 1);
  localparam int BULK = NCLI - 1;

  logic [NCLI-1:0]  gnt_q;
  logic [CW-1:0]    left_q;
  logic [GAP_W-1:0] hold_q;

  logic             busy, last, slot;
  logic [NCLI-1:0]  bulk_mask, elig, pick;
  logic [AW-1:0]    c_addr;
  logic [DW-1:0]    c_wdata;
  logic             c_we;

  assign busy      = |gnt_q;
  assign last      = busy && (left_q == CW'(1));
  assign slot      = (!busy || last) && !cpu_req;
  assign bulk_mask = (thr_en && hold_q != '0) ? (NCLI'(1) << BULK) : '0;
  assign elig      = cli_req & ~bulk_mask;
  assign pick      = elig & (~elig + NCLI'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      left_q <= '0;
      hold_q <= '0;
    end else begin
      if (busy && !last) begin
        left_q <= left_q - CW'(1);
      end else if (slot && elig != '0) begin
        gnt_q  <= pick;
        left_q <= CW'(XFER_CYC);
      end else begin
        gnt_q  <= '0;
        left_q <= '0;
      end

      if (slot && pick[BULK])
        hold_q <= thr_en ? thr_gap : '0;
      else if (slot && hold_q != '0)
        hold_q <= hold_q - GAP_W'(1);
    end
  end

  always_comb begin
    c_addr  = '0;
    c_wdata = '0;
    c_we    = 1'b0;
    for (int k = 0; k < NCLI; k++) begin
      if (gnt_q[k]) begin
        c_addr  = c_addr  | cli_addr[k*AW +: AW];
        c_wdata = c_wdata | cli_wdata[k*DW +: DW];
        c_we    = c_we    | cli_we[k];
      end
    end
  end

  assign mem_en    = busy | cpu_req;
  assign mem_we    = busy ? c_we : (cpu_req & cpu_we);
  assign mem_addr  = busy ? c_addr : cpu_addr;
  assign mem_wdata = busy ? c_wdata : cpu_wdata;

  assign cpu_wait  = cpu_req & busy;
  assign cli_gnt   = gnt_q;
  assign cli_done  = gnt_q & {NCLI{last}};
  assign cpu_rdata = mem_rdata;
  assign cli_rdata = mem_rdata;
endmodule

// File: rtl/mem_bus_arbiter_chk.sv
module mem_bus_arbiter_chk #(
  parameter int NCLI     = 4,
  parameter int AW       = 16,
  parameter int XFER_CYC = 2,
  parameter int GAP_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_wait,
  input logic [AW-1:0]     cpu_addr,
  input logic [AW-1:0]     mem_addr,
  input logic [NCLI-1:0]   cli_req,
  input logic [NCLI-1:0]   cli_gnt,
  input logic [NCLI-1:0]   cli_done,
  input logic              thr_en,
  input logic [GAP_W-1:0]  thr_gap
);
  localparam int LW = $clog2(XFER_CYC + 1);
  logic [LW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)                           run_len <= '0;
    else if (cli_gnt == '0 || cli_done != '0) run_len <= '0;
    else                                  run_len <= run_len + LW'(1);
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cli_gnt)); // R4
  AST_GNT_NOT_TOO_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    (cli_gnt != '0) |-> (run_len < LW'(XFER_CYC))); // R4
  AST_DONE_AT_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cli_done != '0) |-> (run_len == LW'(XFER_CYC - 1))); // R4
  AST_GNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cli_gnt) != '0 && $past(cli_done) == '0) |-> (cli_gnt == $past(cli_gnt))); // R4
  AST_NO_START_UNDER_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cli_gnt == '0) |=> (cli_gnt == '0)); // R3
  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cli_gnt != '0 && ($past(cli_gnt) == '0 || $past(cli_done) != '0))
      |-> (($past(cli_req) & cli_gnt) != '0 && !$past(cpu_req))); // R3
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cli_gnt != '0 && ($past(cli_gnt) == '0 || $past(cli_done) != '0))
      |-> (($past(cli_req) & (cli_gnt - NCLI'(1))) == '0)); // R6
  AST_CPU_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cli_gnt == '0) |-> (!cpu_wait && mem_addr == cpu_addr)); // R2
  AST_WAIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wait && cli_done != '0) |=> (cli_gnt == '0)); // R5
  AST_BULK_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cli_done[NCLI-1] && thr_en && thr_gap != '0) |=> !cli_gnt[NCLI-1]); // R7
endmodule

bind mem_bus_arbiter mem_bus_arbiter_chk #(
  .NCLI(NCLI), .AW(AW), .XFER_CYC(XFER_CYC), .GAP_W(GAP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wait(cpu_wait),
  .cpu_addr(cpu_addr), .mem_addr(mem_addr), .cli_req(cli_req),
  .cli_gnt(cli_gnt), .cli_done(cli_done), .thr_en(thr_en), .thr_gap(thr_gap)
);

// File: tb/mem_bus_arbiter_tb.sv
module mem_bus_arbiter_tb;
  localparam int PERIOD = 10;
  localparam int NCLI = 4, AW = 8, DW = 8, XFER = 2, GW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b1;
  logic [AW-1:0] cpu_addr = 8'hC5;
  logic [DW-1:0] cpu_wdata = 8'hA0, cpu_rdata, cli_rdata, mem_rdata = 8'h00, mem_wdata;
  logic cpu_wait, mem_en, mem_we, thr_en = 1'b0;
  logic [GW-1:0] thr_gap = '0;
  logic [NCLI-1:0] cli_req = '0, cli_we = 4'b1010, cli_gnt, cli_done;
  logic [NCLI*AW-1:0] cli_addr = {8'h23, 8'h22, 8'h21, 8'h20};
  logic [NCLI*DW-1:0] cli_wdata = {8'h33, 8'h32, 8'h31, 8'h30};
  logic [AW-1:0] mem_addr;

  typedef struct {
    logic [NCLI-1:0] gnt;
    logic            wt;
    logic [NCLI-1:0] done;
    int              own;   // 0 idle, 1 processor, 2+k client k
    string           tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  mem_bus_arbiter #(.NCLI(NCLI), .AW(AW), .DW(DW), .XFER_CYC(XFER), .GAP_W(GW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
    .cli_req(cli_req), .cli_we(cli_we), .cli_addr(cli_addr), .cli_wdata(cli_wdata),
    .cli_gnt(cli_gnt), .cli_done(cli_done), .cli_rdata(cli_rdata),
    .thr_en(thr_en), .thr_gap(thr_gap), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  task automatic cyc(input logic c, input logic [NCLI-1:0] r, input logic [NCLI-1:0] g,
                     input logic w, input logic [NCLI-1:0] d, input int own, input string tag);
    exp_t e;
    @(negedge clk);
    cpu_req   = c;
    cli_req   = r;
    mem_rdata = mem_rdata + 8'h17;
    e.gnt = g; e.wt = w; e.done = d; e.own = own; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        logic [AW-1:0] ea;
        logic [DW-1:0] ed;
        logic ew, een;
        e = q.pop_front();
        een = (e.own != 0);
        ea = (e.own == 1) ? cpu_addr : (e.own >= 2) ? cli_addr[(e.own-2)*AW +: AW] : mem_addr;
        ed = (e.own == 1) ? cpu_wdata : (e.own >= 2) ? cli_wdata[(e.own-2)*DW +: DW] : mem_wdata;
        ew = (e.own == 1) ? cpu_we : (e.own >= 2) ? cli_we[e.own-2] : mem_we;
        checks++;
        if (cli_gnt !== e.gnt || cpu_wait !== e.wt || cli_done !== e.done || mem_en !== een ||
            mem_addr !== ea || mem_wdata !== ed || mem_we !== ew) begin
          fails++;
          $display("FAIL %s t=%0t actual gnt=%b wait=%b done=%b en=%b addr=%h wd=%h we=%b expected gnt=%b wait=%b done=%b en=%b addr=%h wd=%h we=%b",
                   e.tag, $time, cli_gnt, cpu_wait, cli_done, mem_en, mem_addr, mem_wdata, mem_we,
                   e.gnt, e.wt, e.done, een, ea, ed, ew);
        end
        checks++;
        if (cpu_rdata !== mem_rdata || cli_rdata !== mem_rdata) begin
          fails++;
          $display("FAIL R10 actual cpu_rdata=%h cli_rdata=%h expected %h", cpu_rdata, cli_rdata, mem_rdata);
        end
      end
    end
  end

  initial begin : driver
    // R1 reset state
    repeat (3) cyc(0, 4'b0000, 4'b0000, 0, 4'b0000, 0, "R1");
    rst_n = 1'b1;
    cyc(0, 4'b0000, 4'b0000, 0, 4'b0000, 0, "R1");
    // R2 processor served directly
    cyc(1, 4'b0000, 4'b0000, 0, 4'b0000, 1, "R2");
    cyc(1, 4'b0000, 4'b0000, 0, 4'b0000, 1, "R2");
    // R4 single client word of two cycles
    cyc(0, 4'b0001, 4'b0000, 0, 4'b0000, 0, "R4");
    cyc(0, 4'b0001, 4'b0001, 0, 4'b0000, 2, "R4");
    cyc(0, 4'b0000, 4'b0001, 0, 4'b0001, 2, "R4");
    cyc(0, 4'b0000, 4'b0000, 0, 4'b0000, 0, "R4");
    // R5 collision: processor waits for in-flight word
    cyc(0, 4'b0100, 4'b0000, 0, 4'b0000, 0, "R5");
    cyc(1, 4'b0100, 4'b0100, 1, 4'b0000, 4, "R5");
    cyc(1, 4'b0000, 4'b0100, 1, 4'b0100, 4, "R5");
    cyc(1, 4'b0000, 4'b0000, 0, 4'b0000, 1, "R5");
    cyc(0, 4'b0000, 4'b0000, 0, 4'b0000, 0, "R5");
    // R3 no client start while processor requests
    repeat (3) cyc(1, 4'b0010, 4'b0000, 0, 4'b0000, 1, "R3");
    cyc(0, 4'b0010, 4'b0000, 0, 4'b0000, 0, "R3");
    cyc(0, 4'b0010, 4'b0010, 0, 4'b0000, 3, "R3");
    cyc(0, 4'b0000, 4'b0010, 0, 4'b0010, 3, "R3");
    cyc(0, 4'b0000, 4'b0000, 0, 4'b0000, 0, "R3");
    // R6 priority, then R8 unthrottled bulk back-to-back
    cyc(0, 4'b1111, 4'b0000, 0, 4'b0000, 0, "R6");
    cyc(0, 4'b1111, 4'b0001, 0, 4'b0000, 2, "R6");
    cyc(0, 4'b1110, 4'b0001, 0, 4'b0001, 2, "R6");
    cyc(0, 4'b1110, 4'b0010, 0, 4'b0000, 3, "R6");
    cyc(0, 4'b1100, 4'b0010, 0, 4'b0010, 3, "R6");
    cyc(0, 4'b1100, 4'b0100, 0, 4'b0000, 4, "R6");
    cyc(0, 4'b1000, 4'b0100, 0, 4'b0100, 4, "R6");
    cyc(0, 4'b1000, 4'b1000, 0, 4'b0000, 5, "R8");
    cyc(0, 4'b1000, 4'b1000, 0, 4'b1000, 5, "R8");
    cyc(0, 4'b1000, 4'b1000, 0, 4'b0000, 5, "R8");
    cyc(0, 4'b0000, 4'b1000, 0, 4'b1000, 5, "R8");
    cyc(0, 4'b0000, 4'b0000, 0, 4'b0000, 0, "R8");
    // R7 throttled bulk: 2 granted, 3 idle
    @(negedge clk);
    thr_en = 1'b1; thr_gap = 4'd3;
    cyc(0, 4'b1000, 4'b0000, 0, 4'b0000, 0, "R7");
    for (int p = 0; p < 2; p++) begin
      cyc(0, 4'b1000, 4'b1000, 0, 4'b0000, 5, "R7");
      cyc(0, 4'b1000, 4'b1000, 0, 4'b1000, 5, "R7");
      repeat (3) cyc(0, 4'b1000, 4'b0000, 0, 4'b0000, 0, "R7");
    end
    cyc(0, 4'b1000, 4'b1000, 0, 4'b0000, 5, "R7");
    cyc(0, 4'b0000, 4'b1000, 0, 4'b1000, 5, "R7");
    repeat (4) cyc(0, 4'b0000, 4'b0000, 0, 4'b0000, 0, "R7");
    // R9 lockout leaves other clients alone
    cyc(0, 4'b1000, 4'b0000, 0, 4'b0000, 0, "R9");
    cyc(0, 4'b1000, 4'b1000, 0, 4'b0000, 5, "R9");
    cyc(0, 4'b0010, 4'b1000, 0, 4'b1000, 5, "R9");
    cyc(0, 4'b0010, 4'b0010, 0, 4'b0000, 3, "R9");
    cyc(0, 4'b0000, 4'b0010, 0, 4'b0010, 3, "R9");
    cyc(0, 4'b1000, 4'b0000, 0, 4'b0000, 0, "R9");
    cyc(0, 4'b1000, 4'b0000, 0, 4'b0000, 0, "R9");
    cyc(0, 4'b1000, 4'b1000, 0, 4'b0000, 5, "R9");
    cyc(0, 4'b0000, 4'b1000, 0, 4'b1000, 5, "R9");
    cyc(0, 4'b0000, 4'b0000, 0, 4'b0000, 0, "R9");
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    #(PERIOD * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule